// File: doc/BRIEF.md
# Floppy Controller Host Register Interface

This block sits between an 8-bit CPU I/O bus and a floppy disk controller chip with its drives. It decodes the CPU's port address, passes four ports straight through to the controller chip, and keeps the board's own control registers. These registers drive the drive-select, motor, density, drive-size, side, fast-seek, eject and firmware-enable lines. On reads it returns either the controller chip's data or one of two status bytes. The status bytes are built from the controller and drive signals together with the current settings.

Software can enable an automatic wait. While it is enabled, a CPU access to the data port stalls the bus until the controller raises its data request. The enable turns itself off when the controller signals command completion. A write-only bank register enables the board. On boards strapped for it, any write to that register also disables the boot firmware, and the firmware stays disabled until the next reset.

Top module: `fdc_host_regs`

## Requirements
- R1: While `bus_rd` or `bus_wr` is high and `bus_addr` is in 0x30..0x33, `fdc_sel` is 1 and `fdc_reg` equals `bus_addr[1:0]`, and a read returns `fdc_rdata` on `bus_rdata`. `fdc_sel` is 0 for every other address.
- R2: After reset, `drive_sel`, `motor_on`, `dbl_density`, `mini_mode`, `side0_sel`, `fast_seek`, `remote_eject`, `fw_enable`, `board_enable` and `fw_disabled` are all 0, and the auto-wait enable is off.
- R3: A write to port 0x34 (the first control register) updates the outputs from the next clock edge. Bit 7 is the auto-wait enable, bit 6 gives `dbl_density`, bit 5 gives `motor_on`, bit 4 gives `mini_mode` (1 = 5.25-inch drive), and bits 3..0 give `drive_sel[3:0]`.
- R4: A read of port 0x34 returns, from bit 7 down to bit 0: `fdc_drq`, `boot_jumper`, `fdc_hld`, `drive_sel[3:0]`, `fdc_intrq`.
- R5: A write to port 0x35 (the second control register) updates the outputs from the next clock edge. Bit 7 is the firmware enable, bit 6 gives `side0_sel`, bit 4 gives `fast_seek`, and bit 2 gives `remote_eject`. Bits 5, 3, 1 and 0 have no effect.
- R6: A read of port 0x35 returns, from bit 7 down to bit 0: `fdc_drq`, `two_sided_n`, `dbl_density`, `index_n`, `side0_sel`, `wprot_n`, `mini_mode`, `trk00`. `side0_sel` = 1 selects side 0 and 0 selects side 1.
- R7: `cpu_wait` is 1 in exactly those cycles where the auto-wait enable is set, port 0x33 is being read or written, and `fdc_drq` is 0. It falls in the same cycle that `fdc_drq` rises.
- R8: A rising edge of `fdc_intrq` clears the auto-wait enable at the next clock edge. A level of `fdc_intrq` that stays high does not clear an enable written afterwards.
- R9: If a write to port 0x34 and an `fdc_intrq` rising edge fall in the same cycle, the auto-wait enable ends up 0 and the other seven bits take the written value.
- R10: A write to port 0x40 sets `board_enable` to `bus_wdata[0]` from the next edge. The other data bits are ignored.
- R11: A write to port 0x40 while `rom_strap` is 1 sets `fw_disabled`, and `fw_disabled` stays set until reset. While `fw_disabled` is set, `fw_enable` is 0 whatever the firmware-enable bit holds. A write to port 0x40 while `rom_strap` is 0 leaves `fw_disabled` unchanged.
- R12: Reads of ports that decode to no readable register (including write-only port 0x40) return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | CPU I/O port address |
| bus_rd | input | 1 | CPU read strobe |
| bus_wr | input | 1 | CPU write strobe |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | Read data to CPU |
| cpu_wait | output | 1 | Wait request to CPU |
| fdc_sel | output | 1 | Controller chip select |
| fdc_reg | output | 2 | Controller register select |
| fdc_rdata | input | 8 | Read data from controller chip |
| fdc_drq | input | 1 | Controller data request |
| fdc_intrq | input | 1 | Controller command-complete interrupt |
| fdc_hld | input | 1 | Controller head-loaded indication |
| boot_jumper | input | 1 | Auto-boot jumper level |
| two_sided_n | input | 1 | Low when a two-sided disk is present |
| index_n | input | 1 | Low at the index hole |
| wprot_n | input | 1 | Low when the disk is write protected |
| trk00 | input | 1 | Track 00 indication |
| rom_strap | input | 1 | Bank writes disable firmware when high |
| drive_sel | output | 4 | Drive select lines |
| motor_on | output | 1 | Spindle motor enable |
| dbl_density | output | 1 | Double-density mode |
| mini_mode | output | 1 | 5.25-inch drive mode |
| side0_sel | output | 1 | 1 selects side 0, 0 selects side 1 |
| fast_seek | output | 1 | Fast seek enable |
| remote_eject | output | 1 | Eject request |
| fw_enable | output | 1 | Boot firmware enable |
| board_enable | output | 1 | Board bank enable |
| fw_disabled | output | 1 | Sticky firmware-disable flag |

## Verification
Two of the block's functions can act on the auto-wait enable in the same clock cycle. One is a CPU write to the first control register. The other is the clear caused by a rising edge of the controller's completion interrupt. The bench provokes this by raising `fdc_intrq` on the same clock edge that a write with bit 7 set lands on port 0x34. It then judges the result at the ports. The drive selects must show the written value, and a data-port access with `fdc_drq` low must not raise `cpu_wait`. A second case writes the enable while the interrupt stays high. That case must leave the wait working, which shows that the clear follows the edge and not the level.

// File: rtl/fdc_host_pkg.sv
package fdc_host_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        PSEL_NONE,
        PSEL_CHIP,
        PSEL_BOARD1,
        PSEL_BOARD2,
        PSEL_BANK
    } port_sel_e;

    typedef struct packed {
        logic       auto_wait;
        logic       dbl_den;
        logic       motor;
        logic       mini;
        logic [3:0] drv;
    } ctl1_t;

    typedef struct packed {
        logic fw_en;
        logic side0;
        logic fast_seek;
        logic eject;
    } ctl2_t;

    typedef struct packed {
        logic drq;
        logic intrq;
        logic hld;
        logic boot;
        logic two_sided_n;
        logic index_n;
        logic wprot_n;
        logic trk00;
    } sense_t;

    function automatic ctl2_t decode_ctl2(input logic [BYTE_W-1:0] d);
        ctl2_t c;
        c.fw_en     = d[7];
        c.side0     = d[6];
        c.fast_seek = d[4];
        c.eject     = d[2];
        return c;
    endfunction

    function automatic logic [BYTE_W-1:0] build_stat1(input sense_t s, input ctl1_t c);
        return {s.drq, s.boot, s.hld, c.drv, s.intrq};
    endfunction

    function automatic logic [BYTE_W-1:0] build_stat2(input sense_t s, input ctl1_t c1,
                                                      input ctl2_t c2);
        return {s.drq, s.two_sided_n, c1.dbl_den, s.index_n,
                c2.side0, s.wprot_n, c1.mini, s.trk00};
    endfunction

endpackage

// File: rtl/fdc_port_decode.sv
module fdc_port_decode
    import fdc_host_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] CHIP_BASE  = 8'h30,
    parameter logic [ADDR_W-1:0] BOARD1_ADR = 8'h34,
    parameter logic [ADDR_W-1:0] BOARD2_ADR = 8'h35,
    parameter logic [ADDR_W-1:0] BANK_ADR   = 8'h40,
    parameter logic [1:0]        DATA_OFS   = 2'd3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output port_sel_e         sel,
    output logic              chip_sel,
    output logic              data_access
);
    localparam int unsigned HI_W = ADDR_W - 2;

    logic in_chip;

    always_comb begin
        in_chip = (addr[ADDR_W-1:2] == CHIP_BASE[ADDR_W-1:2]);
        if (in_chip)                  sel = PSEL_CHIP;
        else if (addr == BOARD1_ADR)  sel = PSEL_BOARD1;
        else if (addr == BOARD2_ADR)  sel = PSEL_BOARD2;
        else if (addr == BANK_ADR)    sel = PSEL_BANK;
        else                          sel = PSEL_NONE;
        chip_sel    = in_chip && (rd || wr);
        data_access = chip_sel && (addr[1:0] == DATA_OFS) && (HI_W > 0);
    end
endmodule

// File: rtl/fdc_ctl_regs.sv
module fdc_ctl_regs
    import fdc_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  port_sel_e         sel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              intrq,
    input  logic              rom_strap,
    output ctl1_t             ctl1,
    output ctl2_t             ctl2,
    output logic              bank_en,
    output logic              fw_kill
);
    logic intrq_q;
    logic intrq_rise;

    assign intrq_rise = intrq && !intrq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            intrq_q <= 1'b0;
            ctl1    <= '0;
            ctl2    <= '0;
            bank_en <= 1'b0;
            fw_kill <= 1'b0;
        end else begin
            intrq_q <= intrq;
            if (wr && sel == PSEL_BOARD1) ctl1 <= ctl1_t'(wdata);
            if (intrq_rise)               ctl1.auto_wait <= 1'b0;
            if (wr && sel == PSEL_BOARD2) ctl2 <= decode_ctl2(wdata);
            if (wr && sel == PSEL_BANK) begin
                bank_en <= wdata[0];
                if (rom_strap) fw_kill <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/fdc_read_mux.sv
module fdc_read_mux
    import fdc_host_pkg::*;
(
    input  port_sel_e         sel,
    input  logic [BYTE_W-1:0] chip_data,
    input  sense_t            sense,
    input  ctl1_t             ctl1,
    input  ctl2_t             ctl2,
    output logic [BYTE_W-1:0] rdata
);
    always_comb begin
        unique case (sel)
            PSEL_CHIP:   rdata = chip_data;
            PSEL_BOARD1: rdata = build_stat1(sense, ctl1);
            PSEL_BOARD2: rdata = build_stat2(sense, ctl1, ctl2);
            default:     rdata = '1;
        endcase
    end
endmodule

// File: rtl/fdc_host_regs.sv
module fdc_host_regs
    import fdc_host_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] bus_addr,
    input  logic       bus_rd,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       cpu_wait,
    output logic       fdc_sel,
    output logic [1:0] fdc_reg,
    input  logic [7:0] fdc_rdata,
    input  logic       fdc_drq,
    input  logic       fdc_intrq,
    input  logic       fdc_hld,
    input  logic       boot_jumper,
    input  logic       two_sided_n,
    input  logic       index_n,
    input  logic       wprot_n,
    input  logic       trk00,
    input  logic       rom_strap,
    output logic [3:0] drive_sel,
    output logic       motor_on,
    output logic       dbl_density,
    output logic       mini_mode,
    output logic       side0_sel,
    output logic       fast_seek,
    output logic       remote_eject,
    output logic       fw_enable,
    output logic       board_enable,
    output logic       fw_disabled
);
    port_sel_e sel;
    logic      data_access;
    ctl1_t     ctl1_q;
    ctl2_t     ctl2_q;
    sense_t    sense;

    fdc_port_decode u_dec (
        .addr        (bus_addr),
        .rd          (bus_rd),
        .wr          (bus_wr),
        .sel         (sel),
        .chip_sel    (fdc_sel),
        .data_access (data_access)
    );

    fdc_ctl_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (bus_wr),
        .sel       (sel),
        .wdata     (bus_wdata),
        .intrq     (fdc_intrq),
        .rom_strap (rom_strap),
        .ctl1      (ctl1_q),
        .ctl2      (ctl2_q),
        .bank_en   (board_enable),
        .fw_kill   (fw_disabled)
    );

    always_comb begin
        sense.drq         = fdc_drq;
        sense.intrq       = fdc_intrq;
        sense.hld         = fdc_hld;
        sense.boot        = boot_jumper;
        sense.two_sided_n = two_sided_n;
        sense.index_n     = index_n;
        sense.wprot_n     = wprot_n;
        sense.trk00       = trk00;
    end

    fdc_read_mux u_mux (
        .sel       (sel),
        .chip_data (fdc_rdata),
        .sense     (sense),
        .ctl1      (ctl1_q),
        .ctl2      (ctl2_q),
        .rdata     (bus_rdata)
    );

    assign fdc_reg      = bus_addr[1:0];
    assign cpu_wait     = ctl1_q.auto_wait && data_access && !fdc_drq;
    assign drive_sel    = ctl1_q.drv;
    assign motor_on     = ctl1_q.motor;
    assign dbl_density  = ctl1_q.dbl_den;
    assign mini_mode    = ctl1_q.mini;
    assign side0_sel    = ctl2_q.side0;
    assign fast_seek    = ctl2_q.fast_seek;
    assign remote_eject = ctl2_q.eject;
    assign fw_enable    = ctl2_q.fw_en && !fw_disabled;
endmodule

// File: rtl/fdc_host_regs_chk.sv
module fdc_host_regs_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] bus_addr,
    input logic       bus_rd,
    input logic       bus_wr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       cpu_wait,
    input logic       fdc_sel,
    input logic       fdc_drq,
    input logic       fdc_intrq,
    input logic       side0_sel,
    input logic       fw_enable,
    input logic       board_enable,
    input logic       fw_disabled,
    input logic       awe
);
    p_sel_range_r1: assert property (@(posedge clk) disable iff (rst)
        fdc_sel |-> (bus_addr[7:2] == 6'b001100) && (bus_rd || bus_wr));

    p_wait_cond_r7: assert property (@(posedge clk) disable iff (rst)
        cpu_wait |-> (!fdc_drq && awe && bus_addr == 8'h33));

    p_intrq_clear_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(fdc_intrq) |=> !awe);

    p_side_echo_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 8'h35) |-> (bus_rdata[3] == side0_sel));

    p_bank_load_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 8'h40) |=> (board_enable == $past(bus_wdata[0])));

    p_kill_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        $past(fw_disabled) |-> fw_disabled);

    p_kill_gate_r11: assert property (@(posedge clk) disable iff (rst)
        fw_disabled |-> !fw_enable);
endmodule

bind fdc_host_regs fdc_host_regs_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_addr     (bus_addr),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .cpu_wait     (cpu_wait),
    .fdc_sel      (fdc_sel),
    .fdc_drq      (fdc_drq),
    .fdc_intrq    (fdc_intrq),
    .side0_sel    (side0_sel),
    .fw_enable    (fw_enable),
    .board_enable (board_enable),
    .fw_disabled  (fw_disabled),
    .awe          (ctl1_q.auto_wait)
);

// File: tb/fdc_host_regs_tb.sv
module fdc_host_regs_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       cpu_wait;
    logic       fdc_sel;
    logic [1:0] fdc_reg;
    logic [7:0] fdc_rdata = 8'h3C;
    logic       fdc_drq = 1'b0, fdc_intrq = 1'b0, fdc_hld = 1'b0, boot_jumper = 1'b0;
    logic       two_sided_n = 1'b1, index_n = 1'b1, wprot_n = 1'b1, trk00 = 1'b0;
    logic       rom_strap = 1'b0;
    logic [3:0] drive_sel;
    logic       motor_on, dbl_density, mini_mode, side0_sel, fast_seek, remote_eject;
    logic       fw_enable, board_enable, fw_disabled;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    fdc_host_regs u_dut (.*);

    // vector: [33:32] op (1 write, 2 read), [31:24] addr, [23:16] wdata,
    // [15:8] pins {drq,boot,hld,intrq,two_n,idx_n,wp_n,trk00}, [7:0] expected read
    localparam int NVEC = 14;
    localparam logic [33:0] VEC [NVEC] = '{
        {2'd1, 8'h34, 8'h35, 8'h00, 8'h00},
        {2'd2, 8'h34, 8'h00, 8'hA0, 8'hAA},
        {2'd2, 8'h35, 8'h00, 8'h85, 8'h93},
        {2'd1, 8'h35, 8'hFF, 8'h00, 8'h00},
        {2'd2, 8'h35, 8'h00, 8'h0A, 8'h4E},
        {2'd1, 8'h34, 8'h4A, 8'h00, 8'h00},
        {2'd2, 8'h34, 8'h00, 8'h50, 8'h55},
        {2'd2, 8'h35, 8'h00, 8'h80, 8'hA8},
        {2'd2, 8'h30, 8'h00, 8'h00, 8'h3C},
        {2'd2, 8'h33, 8'h00, 8'h00, 8'h3C},
        {2'd2, 8'h36, 8'h00, 8'h00, 8'hFF},
        {2'd2, 8'h40, 8'h00, 8'h00, 8'hFF},
        {2'd1, 8'h35, 8'h00, 8'h00, 8'h00},
        {2'd2, 8'h35, 8'h00, 8'h00, 8'h20}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic set_pins(input logic [7:0] p);
        {fdc_drq, boot_jumper, fdc_hld, fdc_intrq, two_sided_n, index_n, wprot_n, trk00} = p;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wait_probe(input string req, input logic [7:0] a, input logic exp);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #2;
        check(req, {7'd0, cpu_wait}, {7'd0, exp});
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++; n_checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2 reset values
        check("R2", {drive_sel, motor_on, dbl_density, mini_mode, side0_sel}, 8'h00);
        check("R2", {fast_seek, remote_eject, fw_enable, board_enable, fw_disabled, 3'b0}, 8'h00);

        // table walk: R1, R4, R6, R12
        for (int i = 0; i < NVEC; i++) begin
            logic [33:0] v;
            logic        exp_sel;
            v = VEC[i];
            @(negedge clk);
            set_pins(v[15:8]);
            bus_addr  = v[31:24];
            bus_wdata = v[23:16];
            bus_wr    = (v[33:32] == 2'd1);
            bus_rd    = (v[33:32] == 2'd2);
            exp_sel   = (v[31:24] >= 8'h30) && (v[31:24] <= 8'h33);
            #2;
            check("R1 sel", {7'd0, fdc_sel}, {7'd0, exp_sel});
            if (exp_sel) check("R1 reg", {6'd0, fdc_reg}, {6'd0, v[25:24]});
            if (v[33:32] == 2'd2) begin
                if (v[31:24] == 8'h34)      check("R4", bus_rdata, v[7:0]);
                else if (v[31:24] == 8'h35) check("R6", bus_rdata, v[7:0]);
                else if (exp_sel)           check("R1 data", bus_rdata, v[7:0]);
                else                        check("R12", bus_rdata, v[7:0]);
            end
            @(negedge clk);
            bus_wr = 1'b0; bus_rd = 1'b0;
        end
        set_pins(8'h00);

        // R3 control 1 outputs
        bus_write(8'h34, 8'h75);
        check("R3", {drive_sel, motor_on, dbl_density, mini_mode, 1'b0}, 8'h5E);
        // R5 control 2 outputs and ignored bits
        bus_write(8'h35, 8'hD4);
        check("R5", {4'd0, fw_enable, side0_sel, fast_seek, remote_eject}, 8'h0F);
        bus_write(8'h35, 8'h2B);
        check("R5 ignored", {4'd0, fw_enable, side0_sel, fast_seek, remote_eject}, 8'h00);

        // R7 auto-wait
        bus_write(8'h34, 8'h80);
        fdc_drq = 1'b0;
        wait_probe("R7 wait on data", 8'h33, 1'b1);
        wait_probe("R7 other port", 8'h32, 1'b0);
        @(negedge clk);
        bus_addr = 8'h33; bus_rd = 1'b1;
        #2 check("R7 held", {7'd0, cpu_wait}, 8'h01);
        fdc_drq = 1'b1;
        #1 check("R7 release", {7'd0, cpu_wait}, 8'h00);
        @(negedge clk);
        bus_rd = 1'b0; fdc_drq = 1'b0;

        // R8 INTRQ edge clears, level does not
        @(negedge clk);
        fdc_intrq = 1'b1;
        wait_probe("R8 clear", 8'h33, 1'b0);
        bus_write(8'h34, 8'h80);
        wait_probe("R8 level", 8'h33, 1'b1);

        // R9 write and INTRQ edge in the same cycle
        @(negedge clk);
        fdc_intrq = 1'b0;
        @(negedge clk);
        bus_addr = 8'h34; bus_wdata = 8'h8F; bus_wr = 1'b1; fdc_intrq = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R9 bits", {4'd0, drive_sel}, 8'h0F);
        wait_probe("R9 enable cleared", 8'h33, 1'b0);

        // R10 bank enable
        bus_write(8'h40, 8'hFE);
        check("R10", {7'd0, board_enable}, 8'h00);
        bus_write(8'h40, 8'h01);
        check("R10", {7'd0, board_enable}, 8'h01);

        // R11 sticky firmware disable
        bus_write(8'h35, 8'h80);
        bus_write(8'h40, 8'h01);
        check("R11 unstrapped", {6'd0, fw_disabled, fw_enable}, 8'h01);
        rom_strap = 1'b1;
        bus_write(8'h40, 8'h01);
        check("R11 strapped", {6'd0, fw_disabled, fw_enable}, 8'h02);
        rom_strap = 1'b0;
        bus_write(8'h35, 8'h80);
        check("R11 sticky", {6'd0, fw_disabled, fw_enable}, 8'h02);

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1 check("R2 after reset", {drive_sel, fw_disabled, fw_enable, board_enable, 1'b0}, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule